// File: doc/BRIEF.md
# Vector Not-Equal / Not-Equal-or-Zero Compare Unit

This unit executes one decoded 32-bit vector compare instruction per handshake. Each instruction carries two 128-bit source vectors. The vectors are cut into equal lanes of 8, 16 or 32 bits. Every lane of the result is then filled with all ones or all zeros, depending on how the two source elements in that lane relate.

Two compare forms are supported. The plain form marks a lane when its elements differ. The zero-aware form also marks a lane when either element is zero, which lets a string scanner find the first mismatch or terminator in one pass. If the record bit of the instruction is set, the unit also produces a 4-bit summary for condition field 6. The summary says whether every lane was marked or whether no lane was marked.

An instruction is taken on a valid/ready handshake. Its outcome is held in a single output register until the consumer takes it. Any word the unit does not recognise comes back as an illegal-instruction response, with no mask and no condition write.

Top module: `vcmpnez_unit`

## Requirements
- R1: While reset is held and right after it is released, outValid, crWrEn and illegal are 0 and inReady is 1.
- R2: The instruction is decoded as follows. Bits [31:26] are the primary opcode and must be 000100. Bit 10 is the record flag. Bits [9:0] are the extended opcode. Bits [25:11] hold the register numbers and do not affect the result.
- R3: The extended opcodes 0100000111, 0101000111 and 0110000111 select the zero-aware form for 8-, 16- and 32-bit lanes. In this form a lane is all ones when the A element is zero, when the B element is zero, or when the two elements differ. Otherwise the lane is all zeros.
- R4: The extended opcodes 0000000111, 0001000111 and 0010000111 select the plain form for 8-, 16- and 32-bit lanes. In this form a lane is all ones only when the two elements differ. Otherwise the lane is all zeros.
- R5: Lanes are numbered from the most significant end. Lane k of width W occupies bits [127-k*W : 128-(k+1)*W]. There are 16, 8 or 4 lanes.
- R6: With the record flag set, crWrEn is 1 together with the result. crField[3] is 1 exactly when every lane is all ones. crField[1] is 1 exactly when no lane is all ones. crField[2] and crField[0] are 0.
- R7: With the record flag clear, crWrEn is 0 for that result.
- R8: Any word that does not match one of the six encodings raises illegal together with outValid. This covers a wrong primary opcode and a wrong extended opcode. The response has resVec equal to zero and crWrEn equal to 0.
- R9: inReady equals !outValid || outReady. An instruction accepted at a clock edge has its result on the outputs after that edge. outValid and the result stay unchanged until an edge at which outReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction and its operands are offered |
| inReady | output | 1 | The unit can take an instruction this cycle |
| instr | input | 32 | Instruction word |
| vecA | input | 128 | Source vector A |
| vecB | input | 128 | Source vector B |
| outValid | output | 1 | A result is held on the outputs |
| outReady | input | 1 | The consumer takes the held result |
| resVec | output | 128 | Lane mask result |
| crField | output | 4 | Summary for condition field 6 |
| crWrEn | output | 1 | crField is to be written |
| illegal | output | 1 | The held response is for an unrecognised instruction |

## Verification
Every result, summary, write enable and illegal flag is due in the cycle right after the clock edge at which inValid and inReady were both high. A behavioural model in the bench keeps its own pending response and updates it at each rising edge, following the same handshake rule. The bench compares all outputs against that model 5 ns after every rising edge, when they have settled. Phases of backpressure hold outReady low for several cycles, so the bench can confirm that the held response stays unchanged until it is consumed.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } elemSize_e;

  typedef struct packed {
    logic      load;      // accept strobe: capture a new response
    logic      bad;       // unrecognised encoding
    logic      zeroMode;  // zero-aware compare form
    logic      record;    // summary write requested
    elemSize_e size;      // lane width
  } cmpCtrl_t;

  localparam logic [5:0] PRIMARY_OP = 6'b000100;

endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output cmpCtrl_t    ctrl
);

  logic       validQ;
  logic       accept;
  logic [5:0] primOp;
  logic [9:0] extOp;
  logic       recBit;
  logic       known;
  logic       zeroSel;
  elemSize_e  sizeSel;
  logic       unusedFields;

  assign primOp       = instr[31:26];
  assign recBit       = instr[10];
  assign extOp        = instr[9:0];
  assign unusedFields = ^instr[25:11];

  assign inReady = !validQ || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    known   = 1'b1;
    zeroSel = 1'b0;
    sizeSel = SZ_BYTE;
    unique case (extOp)
      10'b0000000111: begin zeroSel = 1'b0; sizeSel = SZ_BYTE; end
      10'b0001000111: begin zeroSel = 1'b0; sizeSel = SZ_HALF; end
      10'b0010000111: begin zeroSel = 1'b0; sizeSel = SZ_WORD; end
      10'b0100000111: begin zeroSel = 1'b1; sizeSel = SZ_BYTE; end
      10'b0101000111: begin zeroSel = 1'b1; sizeSel = SZ_HALF; end
      10'b0110000111: begin zeroSel = 1'b1; sizeSel = SZ_WORD; end
      default:        known = 1'b0;
    endcase
    if (primOp != PRIMARY_OP) known = 1'b0;
  end

  always_comb begin
    ctrl.load     = accept;
    ctrl.bad      = !known;
    ctrl.zeroMode = zeroSel;
    ctrl.record   = recBit && known;
    ctrl.size     = sizeSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        validQ <= 1'b0;
    else if (accept)   validQ <= 1'b1;
    else if (outReady) validQ <= 1'b0;
  end

  assign outValid = validQ;

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmpCtrl_t         ctrl,
  input  logic [VEC_W-1:0] vecA,
  input  logic [VEC_W-1:0] vecB,
  output logic [VEC_W-1:0] resQ,
  output logic [3:0]       crQ,
  output logic             wrQ,
  output logic             badQ
);

  localparam int NUM_SIZES = 3;

  logic [VEC_W-1:0]     sizeMask [NUM_SIZES];
  logic [NUM_SIZES-1:0] sizeAll;
  logic [NUM_SIZES-1:0] sizeNone;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int EW = 8 << g;
    localparam int NL = VEC_W / EW;
    logic [NL-1:0]    hit;
    logic [VEC_W-1:0] mask;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0] elemA;
      logic [EW-1:0] elemB;
      logic          differ;
      logic          anyZero;
      assign elemA   = vecA[VEC_W-1-l*EW -: EW];
      assign elemB   = vecB[VEC_W-1-l*EW -: EW];
      assign differ  = elemA != elemB;
      assign anyZero = (elemA == '0) || (elemB == '0);
      assign hit[l]  = differ || (ctrl.zeroMode && anyZero);
      assign mask[VEC_W-1-l*EW -: EW] = {EW{hit[l]}};
    end

    assign sizeMask[g] = mask;
    assign sizeAll[g]  = &hit;
    assign sizeNone[g] = ~|hit;
  end

  logic [VEC_W-1:0] maskSel;
  logic             allSel;
  logic             noneSel;

  always_comb begin
    unique case (ctrl.size)
      SZ_HALF: begin maskSel = sizeMask[1]; allSel = sizeAll[1]; noneSel = sizeNone[1]; end
      SZ_WORD: begin maskSel = sizeMask[2]; allSel = sizeAll[2]; noneSel = sizeNone[2]; end
      default: begin maskSel = sizeMask[0]; allSel = sizeAll[0]; noneSel = sizeNone[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resQ <= '0;
      crQ  <= '0;
      wrQ  <= 1'b0;
      badQ <= 1'b0;
    end else if (ctrl.load) begin
      badQ <= ctrl.bad;
      if (ctrl.bad) begin
        resQ <= '0;
        crQ  <= '0;
        wrQ  <= 1'b0;
      end else begin
        resQ <= maskSel;
        crQ  <= {allSel, 1'b0, noneSel, 1'b0};
        wrQ  <= ctrl.record;
      end
    end
  end

  p_cr_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrQ |-> (crQ[2] == 1'b0 && crQ[0] == 1'b0 && !(crQ[3] && crQ[1])));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    badQ |-> (!wrQ && resQ == '0));

endmodule

// File: rtl/vcmpnez_unit.sv
module vcmpnez_unit
  import vcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  input  logic [31:0]  instr,
  input  logic [127:0] vecA,
  input  logic [127:0] vecB,
  output logic         outValid,
  input  logic         outReady,
  output logic [127:0] resVec,
  output logic [3:0]   crField,
  output logic         crWrEn,
  output logic         illegal
);

  cmpCtrl_t ctrl;
  logic     wrQ;
  logic     badQ;

  vcmp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctrl     (ctrl)
  );

  vcmp_lanes #(.VEC_W(128)) u_lanes (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .vecA  (vecA),
    .vecB  (vecB),
    .resQ  (resVec),
    .crQ   (crField),
    .wrQ   (wrQ),
    .badQ  (badQ)
  );

  assign crWrEn  = wrQ && outValid;
  assign illegal = badQ && outValid;

  p_stable_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(resVec) && $stable(crField)
                                 && $stable(crWrEn) && $stable(illegal)));

endmodule

// File: tb/vcmpnez_unit_test.sv
module vcmpnez_unit_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [31:0]  instr = '0;
  logic [127:0] vecA = '0;
  logic [127:0] vecB = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] resVec;
  logic [3:0]   crField;
  logic         crWrEn;
  logic         illegal;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit checkOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcmpnez_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .instr(instr), .vecA(vecA), .vecB(vecB), .outValid(outValid),
    .outReady(outReady), .resVec(resVec), .crField(crField),
    .crWrEn(crWrEn), .illegal(illegal)
  );

  // reference model state
  bit           expValid = 1'b0;
  logic [127:0] expRes = '0;
  logic [3:0]   expCr = '0;
  bit           expWr = 1'b0;
  bit           expBad = 1'b0;
  bit           expZero = 1'b0;

  function automatic [31:0] mk(input logic [5:0] prim, input logic [9:0] xo, input logic rc);
    mk = {prim, 5'd7, 5'd12, 5'd30, rc, xo};
  endfunction

  task automatic refCalc(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                         output logic [127:0] r, output logic [3:0] cr,
                         output bit wr, output bit bad, output bit zm);
    int ew;
    int nl;
    bit ok;
    bit allT;
    bit noneT;
    logic [127:0] ea;
    logic [127:0] eb;
    logic [127:0] em;
    ok = 1'b1; ew = 8; zm = 1'b0;
    case (ins[9:0])
      10'b0000000111: ew = 8;
      10'b0001000111: ew = 16;
      10'b0010000111: ew = 32;
      10'b0100000111: begin ew = 8;  zm = 1'b1; end
      10'b0101000111: begin ew = 16; zm = 1'b1; end
      10'b0110000111: begin ew = 32; zm = 1'b1; end
      default: ok = 1'b0;
    endcase
    if (ins[31:26] != 6'b000100) ok = 1'b0;
    r = '0; cr = '0; wr = 1'b0; bad = !ok;
    if (ok) begin
      nl = 128 / ew;
      em = (128'd1 << ew) - 128'd1;
      allT = 1'b1; noneT = 1'b1;
      for (int i = 0; i < nl; i++) begin
        bit h;
        ea = (a >> (128 - (i + 1) * ew)) & em;
        eb = (b >> (128 - (i + 1) * ew)) & em;
        h = (ea != eb) || (zm && (ea == 0 || eb == 0));
        if (h) r = r | (em << (128 - (i + 1) * ew));
        allT = allT && h;
        noneT = noneT && !h;
      end
      wr = ins[10];
      cr = {allT, 1'b0, noneT, 1'b0};
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      expValid = 1'b0;
    end else begin
      bit acc;
      acc = inValid && (!expValid || outReady);
      if (expValid && outReady) expValid = 1'b0;
      if (acc) begin
        refCalc(instr, vecA, vecB, expRes, expCr, expWr, expBad, expZero);
        expValid = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (checkOn && rst_n) begin
      chk(outValid == expValid, "R9 outValid", 128'(outValid), 128'(expValid));
      chk(inReady == (!expValid || outReady), "R9 inReady", 128'(inReady), 128'(!expValid || outReady));
      if (expValid) begin
        chk(resVec == expRes, expZero ? "R3 R5 resVec" : "R4 R5 resVec", resVec, expRes);
        chk(illegal == expBad, "R8 R2 illegal", 128'(illegal), 128'(expBad));
        chk(crWrEn == expWr, expWr ? "R6 crWrEn" : "R7 crWrEn", 128'(crWrEn), 128'(expWr));
        if (expWr) chk(crField == expCr, "R6 crField", 128'(crField), 128'(expCr));
      end else begin
        chk(!crWrEn && !illegal, "R7 R8 idle flags", 128'({crWrEn, illegal}), 128'(0));
      end
    end
  end

  task automatic issue(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b, input bit rdy);
    @(negedge clk);
    outReady = rdy;
    instr = ins; vecA = a; vecB = b; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      outReady = 1'b1;
      #1;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic [127:0] rnd128();
    rnd128 = {$urandom, $urandom, $urandom, $urandom};
  endfunction

  localparam logic [5:0] OP = 6'b000100;
  logic [9:0] xoList [6] = '{10'b0000000111, 10'b0001000111, 10'b0010000111,
                             10'b0100000111, 10'b0101000111, 10'b0110000111};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(!outValid && !crWrEn && !illegal && inReady, "R1 reset held",
        128'({outValid, crWrEn, illegal, inReady}), 128'(4'b0001));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!outValid && !crWrEn && !illegal && inReady, "R1 after release",
        128'({outValid, crWrEn, illegal, inReady}), 128'(4'b0001));
    checkOn = 1'b1;

    // directed patterns on each encoding, both record settings
    for (int k = 0; k < 6; k++) begin
      for (int rc = 0; rc < 2; rc++) begin
        issue(mk(OP, xoList[k], rc[0]), {16{8'h5a}}, {16{8'h5a}}, 1'b1);        // equal nonzero
        issue(mk(OP, xoList[k], rc[0]), '0, {16{8'h11}}, 1'b1);                 // A zero
        issue(mk(OP, xoList[k], rc[0]), {16{8'h01}}, {16{8'h02}}, 1'b1);        // all differ
        issue(mk(OP, xoList[k], rc[0]), {8'h80, 120'h0}, 128'h0, 1'b1);         // top lane only
        issue(mk(OP, xoList[k], rc[0]), {120'h1, 8'h00}, {120'h1, 8'h00}, 1'b1); // zero in last byte
        issue(mk(OP, xoList[k], rc[0]), rnd128(), rnd128(), 1'b1);
      end
    end

    // R2: register fields do not matter
    issue({OP, 5'd31, 5'd0, 5'd17, 1'b1, 10'b0101000111}, {8{16'h1234}}, {8{16'h1234}}, 1'b1);

    // R8: unknown extended opcode and wrong primary opcode
    issue(mk(OP, 10'b0011000111, 1'b1), {16{8'h01}}, {16{8'h02}}, 1'b1);
    issue(mk(OP, 10'b0100000110, 1'b0), '0, '0, 1'b1);
    issue(mk(6'b000101, 10'b0100000111, 1'b1), '0, '0, 1'b1);

    // R9: backpressure, response held then a queued request waits
    issue(mk(OP, 10'b0100000111, 1'b1), {16{8'h33}}, {16{8'h33}}, 1'b0);
    repeat (4) @(negedge clk);
    issue(mk(OP, 10'b0001000111, 1'b1), rnd128(), rnd128(), 1'b0);
    repeat (3) @(negedge clk);
    outReady = 1'b1;

    // random traffic with random backpressure
    for (int n = 0; n < 300; n++) begin
      logic [127:0] a;
      logic [127:0] b;
      logic [9:0] xo;
      a = rnd128();
      b = ($urandom % 3 == 0) ? a : rnd128();
      if ($urandom % 4 == 0) b[63:32] = '0;
      xo = ($urandom % 10 == 0) ? 10'($urandom) : xoList[$urandom % 6];
      issue(mk(OP, xo, 1'($urandom)), a, b, 1'($urandom));
    end

    outReady = 1'b1;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule